// File: doc/BRIEF.md
# Conditionally Executed Integer ALU with Status Flags

This block is the data-processing stage of a 32-bit load/store core with sixteen general registers. Each cycle it may receive one decoded arithmetic or logical operation. The operation comes with a 4-bit condition selector, a flag-update request, and the part of the instruction word that holds the two register indices. The register file lies outside the block. The block hands the file the index of the first operand and gets back its value. The shifted second operand and the shifter's carry-out come from a shifter that is also outside the block.

The block owns the 32-bit status register: the N, Z, C and V flags, the compact-instruction bit and a 5-bit privilege mode. It tests the selected condition against the current flags. If the test fails, the operation is dropped. If it passes, the block drives the register write and may update the flags on the same clock edge. One case is special: a flag-setting operation that targets register 15 while the core is in a privileged mode with a saved status copy. In that case the whole status register is reloaded from the saved copy. The compact-instruction bit then decides whether the fetch stride is 2 or 4 bytes.

Top module: `cond_alu`

## Requirements
- R1: `ifield` carries instruction bits 19:12. `rn_idx` is `ifield[7:4]` (first operand) and `rf_waddr` is `ifield[3:0]` (destination). Both are combinational.
- R2: The `cond` codes and their pass tests are:
  - 0: Z
  - 1: !Z
  - 2: C
  - 3: !C
  - 4: N
  - 5: !N
  - 6: V
  - 7: !V
  - 8: C&!Z
  - 9: !C|Z
  - 10: N==V
  - 11: N!=V
  - 12: !Z&(N==V)
  - 13: Z|(N!=V)
  - 14: always
  - 15: never
- R3: If `issue` is high and the condition fails, `rf_we` stays low and the status register does not change.
- R4: `op` selects the result as follows:
  - 0 (AND): rn&op2
  - 1 (EOR): rn^op2
  - 2 (SUB): rn-op2
  - 3 (RSB): op2-rn
  - 4 (ADD): rn+op2
  - 5 (ADC): rn+op2+C
  - 6 (SBC): rn-op2-!C
  - 7 (RSC): op2-rn-!C

  The result appears on `rf_wdata` with `rf_we` high in the issue cycle.
- R5: For ADD and ADC, C is the carry out of the exact 33-bit sum, including the carry-in. V is set when both addends share a sign and the result's sign differs from it.
- R6: For the four subtract forms, C is 1 exactly when the minuend is at least the subtrahend plus the borrow-in, compared as exact unsigned values. V is set when minuend and subtrahend differ in sign and the result's sign differs from the minuend's.
- R7: For AND and EOR with flag update, C takes `sh_carry` and V keeps its old value.
- R8: With flag update, N is result bit 31 and Z is set for an all-zero result. Without flag update the status register is unchanged.
- R9: The status register layout is N at bit 31, Z at bit 30, C at bit 29, V at bit 28, compact bit at bit 5 and mode at bits 4:0. When the condition passes, the flag update is requested, the destination is 15, and the mode is neither 0x10 nor 0x1F, the status register becomes `saved_psr`. The result is still written.
- R10: `step` is 2 when the compact bit is 1 and 4 otherwise.
- R11: After reset the status register is 0x0000001F and `step` is 4.
- R12: `psr_wr` loads `psr_wdata` at the clock edge and takes priority over any update from an operation in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An operation is presented this cycle |
| op | input | 3 | Operation select |
| cond | input | 4 | Condition selector |
| set_flags | input | 1 | Update status on completion |
| ifield | input | 8 | Instruction bits 19:12 |
| rn_val | input | 32 | First operand read from the register file |
| op2 | input | 32 | Shifted second operand |
| sh_carry | input | 1 | Shifter carry-out |
| saved_psr | input | 32 | Saved status copy of the current mode |
| psr_wr | input | 1 | Direct status load strobe |
| psr_wdata | input | 32 | Direct status load value |
| rn_idx | output | 4 | First-operand read index |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 4 | Register write index |
| rf_wdata | output | 32 | Register write data |
| psr | output | 32 | Current status register |
| step | output | 3 | Fetch stride in bytes |

## Verification
A flag-setting operation that targets register 15 in a privileged mode both writes the result to the program counter and reloads the full status register, on one edge. The bench sets a privileged mode through the direct load, then issues such an operation with a saved copy whose flags, compact bit and mode all differ from the live value. It checks that the write port showed index 15 with the computed value during the issue cycle. After the edge it checks that the status equals the saved copy and that the stride dropped to 2. A second collision is also tested: a direct status load in the same cycle as a flag-setting operation, where the load value must win.

// File: rtl/cond_alu.sv
module cond_alu #(
  parameter int          XLEN      = 32,
  parameter logic [4:0]  MODE_USER = 5'h10,
  parameter logic [4:0]  MODE_SYS  = 5'h1F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [2:0]      op,
  input  logic [3:0]      cond,
  input  logic            set_flags,
  input  logic [7:0]      ifield,
  input  logic [XLEN-1:0] rn_val,
  input  logic [XLEN-1:0] op2,
  input  logic            sh_carry,
  input  logic [31:0]     saved_psr,
  input  logic            psr_wr,
  input  logic [31:0]     psr_wdata,
  output logic [3:0]      rn_idx,
  output logic            rf_we,
  output logic [3:0]      rf_waddr,
  output logic [XLEN-1:0] rf_wdata,
  output logic [31:0]     psr,
  output logic [2:0]      step
);
  localparam int MSB = XLEN - 1;
  localparam int NB = 31, ZB = 30, CB = 29, VB = 28, TB = 5;
  localparam logic [31:0] PSR_RST = {27'd0, MODE_SYS};
  localparam logic [2:0] OP_AND = 3'd0, OP_EOR = 3'd1, OP_SUB = 3'd2, OP_RSB = 3'd3,
                         OP_ADD = 3'd4, OP_ADC = 3'd5, OP_SBC = 3'd6, OP_RSC = 3'd7;

  logic [3:0] rd_idx;
  logic fn, fz, fc, fv, cond_ok, is_logic, exec, privileged, restore, ov;
  logic [XLEN-1:0] a, b, result;
  logic ci;
  logic [XLEN:0] sum;
  logic [31:0] psr_nx;

  // R1
  assign rd_idx   = ifield[3:0];
  assign rn_idx   = ifield[7:4];
  assign fn = psr[NB];
  assign fz = psr[ZB];
  assign fc = psr[CB];
  assign fv = psr[VB];

  // R2
  always_comb begin
    case (cond)
      4'd0:    cond_ok = fz;
      4'd1:    cond_ok = !fz;
      4'd2:    cond_ok = fc;
      4'd3:    cond_ok = !fc;
      4'd4:    cond_ok = fn;
      4'd5:    cond_ok = !fn;
      4'd6:    cond_ok = fv;
      4'd7:    cond_ok = !fv;
      4'd8:    cond_ok = fc && !fz;
      4'd9:    cond_ok = !fc || fz;
      4'd10:   cond_ok = (fn == fv);
      4'd11:   cond_ok = (fn != fv);
      4'd12:   cond_ok = !fz && (fn == fv);
      4'd13:   cond_ok = fz || (fn != fv);
      4'd14:   cond_ok = 1'b1;
      default: cond_ok = 1'b0;
    endcase
  end

  // R4..R6: one adder serves every arithmetic form
  always_comb begin
    a  = rn_val;
    b  = op2;
    ci = 1'b0;
    case (op)
      OP_ADC: ci = fc;
      OP_SUB: begin b = ~op2; ci = 1'b1; end
      OP_SBC: begin b = ~op2; ci = fc; end
      OP_RSB: begin a = op2; b = ~rn_val; ci = 1'b1; end
      OP_RSC: begin a = op2; b = ~rn_val; ci = fc; end
      default: ;
    endcase
  end

  assign sum      = {1'b0, a} + {1'b0, b} + {{XLEN{1'b0}}, ci};
  assign is_logic = (op == OP_AND) || (op == OP_EOR);
  assign ov       = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);

  always_comb begin
    case (op)
      OP_AND:  result = rn_val & op2;
      OP_EOR:  result = rn_val ^ op2;
      OP_ADD:  result = sum[MSB:0];
      default: result = sum[MSB:0];
    endcase
  end

  assign exec       = issue && cond_ok;
  assign privileged = (psr[4:0] != MODE_USER) && (psr[4:0] != MODE_SYS);
  assign restore    = exec && set_flags && (rd_idx == 4'd15) && privileged;

  assign rf_we    = exec;
  assign rf_waddr = rd_idx;
  assign rf_wdata = result;

  always_comb begin
    psr_nx = psr;
    if (psr_wr) begin
      psr_nx = psr_wdata;
    end else if (restore) begin
      psr_nx = saved_psr;
    end else if (exec && set_flags) begin
      psr_nx[NB] = result[MSB];
      psr_nx[ZB] = (result == '0);
      psr_nx[CB] = is_logic ? sh_carry : sum[XLEN];
      if (!is_logic) psr_nx[VB] = ov;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) psr <= PSR_RST;
    else        psr <= psr_nx;
  end

  // R10
  assign step = psr[TB] ? 3'd2 : 3'd4;

  AST_FAIL_HOLDS_PSR: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !cond_ok && !psr_wr) |=> $stable(psr)); // R3
  AST_AL_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && cond == 4'd14) |-> rf_we); // R2
  AST_NO_S_HOLDS_PSR: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_flags && !psr_wr) |=> $stable(psr)); // R8
  AST_LOGIC_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && set_flags && is_logic && !restore && !psr_wr) |=> (psr[VB] == $past(psr[VB]))); // R7
  AST_RESTORE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (restore && !psr_wr) |=> (psr == $past(saved_psr))); // R9
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && set_flags && !restore && !psr_wr) |=> (psr[ZB] == ($past(rf_wdata) == '0))); // R8
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    psr_wr |=> (psr == $past(psr_wdata))); // R12
endmodule

// File: tb/sim_cond_alu.sv
module sim_cond_alu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue = 1'b0, set_flags = 1'b0, sh_carry = 1'b0, psr_wr = 1'b0;
  logic [2:0] op = '0;
  logic [3:0] cond = '0;
  logic [7:0] ifield = '0;
  logic [31:0] rn_val = '0, op2 = '0, saved_psr = '0, psr_wdata = '0;
  logic [3:0] rn_idx, rf_waddr;
  logic rf_we;
  logic [31:0] rf_wdata, psr;
  logic [2:0] step;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  cond_alu u0 (.clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .cond(cond),
    .set_flags(set_flags), .ifield(ifield), .rn_val(rn_val), .op2(op2), .sh_carry(sh_carry),
    .saved_psr(saved_psr), .psr_wr(psr_wr), .psr_wdata(psr_wdata), .rn_idx(rn_idx),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .psr(psr), .step(step));

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  cond;
    logic        s;
    logic [31:0] a;
    logic [31:0] b;
    logic        shc;
    logic [3:0]  fin;
    logic        we;
    logic [31:0] res;
    logic [3:0]  fout;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VT [NV] = '{
    '{3'd4, 4'd14, 1'b1, 32'd1,          32'd2,          1'b0, 4'b0000, 1'b1, 32'd3,          4'b0000}, // R4 R5
    '{3'd4, 4'd14, 1'b1, 32'hFFFFFFFF,   32'd1,          1'b0, 4'b0000, 1'b1, 32'd0,          4'b0110}, // R5 R8
    '{3'd4, 4'd14, 1'b1, 32'h7FFFFFFF,   32'd1,          1'b0, 4'b0000, 1'b1, 32'h80000000,   4'b1001}, // R5
    '{3'd5, 4'd14, 1'b1, 32'd5,          32'd6,          1'b0, 4'b0010, 1'b1, 32'd12,         4'b0000}, // R5
    '{3'd5, 4'd14, 1'b1, 32'hFFFFFFFF,   32'd0,          1'b0, 4'b0010, 1'b1, 32'd0,          4'b0110}, // R5
    '{3'd2, 4'd14, 1'b1, 32'd5,          32'd3,          1'b0, 4'b0000, 1'b1, 32'd2,          4'b0010}, // R6
    '{3'd2, 4'd14, 1'b1, 32'd3,          32'd5,          1'b0, 4'b0000, 1'b1, 32'hFFFFFFFE,   4'b1000}, // R6
    '{3'd2, 4'd14, 1'b1, 32'h80000000,   32'd1,          1'b0, 4'b0000, 1'b1, 32'h7FFFFFFF,   4'b0011}, // R6
    '{3'd3, 4'd14, 1'b1, 32'd3,          32'd10,         1'b0, 4'b0000, 1'b1, 32'd7,          4'b0010}, // R6
    '{3'd6, 4'd14, 1'b1, 32'd10,         32'd3,          1'b0, 4'b0000, 1'b1, 32'd6,          4'b0010}, // R6
    '{3'd6, 4'd14, 1'b1, 32'd0,          32'hFFFFFFFF,   1'b0, 4'b0000, 1'b1, 32'd0,          4'b0100}, // R6 corner
    '{3'd7, 4'd14, 1'b1, 32'd4,          32'd4,          1'b0, 4'b0000, 1'b1, 32'hFFFFFFFF,   4'b1000}, // R6
    '{3'd0, 4'd14, 1'b1, 32'h0000F0F0,   32'h00000FF0,   1'b1, 4'b0001, 1'b1, 32'h000000F0,   4'b0011}, // R7
    '{3'd1, 4'd14, 1'b1, 32'hA5A5A5A5,   32'hA5A5A5A5,   1'b0, 4'b1111, 1'b1, 32'd0,          4'b0101}, // R7
    '{3'd4, 4'd14, 1'b0, 32'd1,          32'd1,          1'b0, 4'b1010, 1'b1, 32'd2,          4'b1010}, // R8
    '{3'd4, 4'd0,  1'b1, 32'd0,          32'd0,          1'b0, 4'b0000, 1'b0, 32'd0,          4'b0000}, // R3
    '{3'd4, 4'd1,  1'b1, 32'd1,          32'd1,          1'b0, 4'b0000, 1'b1, 32'd2,          4'b0000}, // R2
    '{3'd4, 4'd8,  1'b0, 32'd1,          32'd1,          1'b0, 4'b0010, 1'b1, 32'd2,          4'b0010}, // R2
    '{3'd4, 4'd8,  1'b0, 32'd1,          32'd1,          1'b0, 4'b0110, 1'b0, 32'd0,          4'b0110}, // R2
    '{3'd4, 4'd9,  1'b0, 32'd1,          32'd1,          1'b0, 4'b0110, 1'b1, 32'd2,          4'b0110}, // R2
    '{3'd4, 4'd10, 1'b0, 32'd1,          32'd1,          1'b0, 4'b1001, 1'b1, 32'd2,          4'b1001}, // R2
    '{3'd4, 4'd11, 1'b0, 32'd1,          32'd1,          1'b0, 4'b1000, 1'b1, 32'd2,          4'b1000}, // R2
    '{3'd4, 4'd11, 1'b0, 32'd1,          32'd1,          1'b0, 4'b1001, 1'b0, 32'd0,          4'b1001}, // R2
    '{3'd4, 4'd12, 1'b0, 32'd1,          32'd1,          1'b0, 4'b0000, 1'b1, 32'd2,          4'b0000}, // R2
    '{3'd4, 4'd12, 1'b0, 32'd1,          32'd1,          1'b0, 4'b0100, 1'b0, 32'd0,          4'b0100}, // R2
    '{3'd4, 4'd13, 1'b0, 32'd1,          32'd1,          1'b0, 4'b0100, 1'b1, 32'd2,          4'b0100}, // R2
    '{3'd4, 4'd4,  1'b0, 32'd1,          32'd1,          1'b0, 4'b1000, 1'b1, 32'd2,          4'b1000}, // R2
    '{3'd4, 4'd5,  1'b0, 32'd1,          32'd1,          1'b0, 4'b1000, 1'b0, 32'd0,          4'b1000}, // R2
    '{3'd4, 4'd6,  1'b0, 32'd1,          32'd1,          1'b0, 4'b0001, 1'b1, 32'd2,          4'b0001}, // R2
    '{3'd4, 4'd7,  1'b0, 32'd1,          32'd1,          1'b0, 4'b0001, 1'b0, 32'd0,          4'b0001}, // R2
    '{3'd4, 4'd2,  1'b0, 32'd1,          32'd1,          1'b0, 4'b0010, 1'b1, 32'd2,          4'b0010}, // R2
    '{3'd4, 4'd3,  1'b0, 32'd1,          32'd1,          1'b0, 4'b0010, 1'b0, 32'd0,          4'b0010}, // R2
    '{3'd4, 4'd15, 1'b1, 32'd1,          32'd1,          1'b0, 4'b0000, 1'b0, 32'd0,          4'b0000}  // R2 R3
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_psr(input logic [31:0] v);
    @(negedge clk);
    psr_wr = 1'b1; psr_wdata = v;
    @(negedge clk);
    psr_wr = 1'b0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset psr", psr, 32'h0000001F);
    check("R11 reset step", {29'd0, step}, 32'd4);
    rst_n = 1'b1;

    ifield = {4'd9, 4'd4};
    #1;
    check("R1 rn_idx", {28'd0, rn_idx}, 32'd9);
    check("R1 rf_waddr", {28'd0, rf_waddr}, 32'd4);

    for (int i = 0; i < NV; i++) begin
      load_psr({VT[i].fin, 23'd0, 5'h1F});
      issue = 1'b1; op = VT[i].op; cond = VT[i].cond; set_flags = VT[i].s;
      ifield = {4'd1, 4'd2}; rn_val = VT[i].a; op2 = VT[i].b; sh_carry = VT[i].shc;
      #1;
      check($sformatf("R2/R3 vec%0d we", i), {31'd0, rf_we}, {31'd0, VT[i].we});
      if (VT[i].we) check($sformatf("R4 vec%0d result", i), rf_wdata, VT[i].res);
      @(negedge clk);
      issue = 1'b0;
      check($sformatf("R5-R8 vec%0d flags", i), {28'd0, psr[31:28]}, {28'd0, VT[i].fout});
    end

    // R9 restore in privileged mode, result still written to 15
    load_psr(32'h00000012);
    saved_psr = 32'hA0000033;
    issue = 1'b1; op = 3'd2; cond = 4'd14; set_flags = 1'b1;
    ifield = {4'd3, 4'd15}; rn_val = 32'd100; op2 = 32'd4;
    #1;
    check("R9 pc write en", {31'd0, rf_we}, 32'd1);
    check("R9 pc write idx", {28'd0, rf_waddr}, 32'd15);
    check("R9 pc write data", rf_wdata, 32'd96);
    @(negedge clk);
    issue = 1'b0;
    check("R9 restored psr", psr, 32'hA0000033);
    check("R10 compact step", {29'd0, step}, 32'd2);

    // R9 user mode: no restore, normal flags
    load_psr(32'h00000010);
    check("R10 wide step", {29'd0, step}, 32'd4);
    issue = 1'b1; op = 3'd2; cond = 4'd14; set_flags = 1'b1;
    ifield = {4'd3, 4'd15}; rn_val = 32'd5; op2 = 32'd5;
    @(negedge clk);
    issue = 1'b0;
    check("R9 user mode flags", psr, 32'h60000010);

    // R9 system mode: no restore
    load_psr(32'h0000001F);
    issue = 1'b1; op = 3'd4; cond = 4'd14; set_flags = 1'b1;
    ifield = {4'd3, 4'd15}; rn_val = 32'h80000000; op2 = 32'd0;
    @(negedge clk);
    issue = 1'b0;
    check("R9 system mode flags", psr, 32'h8000001F);

    // R12 direct load collides with a flag-setting operation
    issue = 1'b1; op = 3'd4; cond = 4'd14; set_flags = 1'b1;
    ifield = {4'd3, 4'd2}; rn_val = 32'd0; op2 = 32'd0;
    psr_wr = 1'b1; psr_wdata = 32'h10000013;
    @(negedge clk);
    issue = 1'b0; psr_wr = 1'b0;
    check("R12 load wins", psr, 32'h10000013);

    // R11 reset again
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset reapplied", psr, 32'h0000001F);
    rst_n = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule